// File: doc/BRIEF.md
# Multi-Mode Built-In Test Register

This block is one register stage that sits between two clouds of combinational logic and supports built-in self-test. A two-bit mode code selects one of four jobs for the same chain of flops. It can work as an ordinary register that captures a data word. It can work as a serial scan chain, which shifts a seed in or a result out. It can work as a linear-feedback shift register. In that mode the register either generates pseudo-random patterns or compacts the responses arriving on its data word into a signature. The fourth job is a synchronous clear.

A pattern-generation control input replaces the data word with all ones, so that in feedback mode the register runs by itself as a stimulus source. The feedback taps come from a primitive polynomial that is fixed for each width from 3 to 16. With a nonzero seed and a zero data word, the state therefore walks through every nonzero value before it repeats. Ordering several of these registers and loading the expected signatures is the work of an outside controller.

Top module: `bilbo_reg`

## Requirements
- R1: With mode code 2'b11 (bit 0 high, bit 1 high), the state loads the data word `d_i` on the next clock edge.
- R2: With mode code 2'b00, the state shifts by one stage per edge: stage 0 takes `scan_i` and stage i takes stage i-1. The data word and `pgen_i` have no effect.
- R3: With mode code 2'b01 and `pgen_i` low, stage 0 takes feedback XOR `d_i[0]` and stage i takes stage i-1 XOR `d_i[i]`. The feedback is the XOR of the last stage with stage W-1-k for each middle exponent k of the width's primitive polynomial (for width 8: x^8+x^6+x^5+x^4+1, so the taps are stages 7, 1, 2 and 3).
- R4: With mode code 2'b10, every stage is 0 after the next edge.
- R5: With mode code 2'b01 and `pgen_i` high, every data bit is taken as 1. Stage i (i>0) then becomes the inverse of stage i-1, and the value of `d_i` has no effect.
- R6: `pgen_i` has no effect in parallel-load mode.
- R7: `scan_o` equals the last stage of the state in every mode.
- R8: While `rst_ni` is low the state is 0 at once, whatever the mode. Release is synchronised to the clock over two edges.
- R9: In feedback mode, with `pgen_i` low, `d_i` zero and a nonzero seed, the state returns to the seed after exactly 2^W-1 steps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Mode code: bit 0 and bit 1 select load, scan, feedback or clear |
| pgen_i | input | 1 | Force the data word to all ones in feedback mode |
| d_i | input | WIDTH | Parallel data or response word |
| scan_i | input | 1 | Serial input to stage 0 |
| q_o | output | WIDTH | Register state |
| scan_o | output | 1 | Serial output, the last stage |

## Verification
On every cycle, the assertions check the step taken in each mode. A load captures the data word, a clear empties the state, a scan moves each bit one stage along, the pattern-generation inversion holds, and stage 0 in feedback mode matches the feedback network's output XOR its data bit. The full length of the feedback sequence cannot be seen from a single step, and neither can the asynchronous reset in the middle of a run or the fact that the data word is ignored during pattern generation. Only the bench's directed scenarios show those, next to a random mix of modes checked against a reference model.

// File: rtl/bilbo_pkg.sv
package bilbo_pkg;

  // bit 0 and bit 1 of the mode code
  typedef enum logic [1:0] {
    MODE_SCAN  = 2'b00,
    MODE_LFSR  = 2'b01,
    MODE_CLEAR = 2'b10,
    MODE_LOAD  = 2'b11
  } bilbo_mode_e;

  localparam int unsigned MAX_WIDTH = 16;
  localparam int unsigned MIN_WIDTH = 3;

  // middle exponents (between 1 and w-1) of a primitive polynomial of degree w
  function automatic logic [MAX_WIDTH-1:0] poly_mid_terms(input int unsigned w);
    logic [MAX_WIDTH-1:0] m;
    m = '0;
    case (w)
      3:  m[1] = 1'b1;
      4:  m[1] = 1'b1;
      5:  m[2] = 1'b1;
      6:  m[1] = 1'b1;
      7:  m[1] = 1'b1;
      8:  begin m[6] = 1'b1; m[5] = 1'b1; m[4] = 1'b1; end
      9:  m[4] = 1'b1;
      10: m[3] = 1'b1;
      11: m[2] = 1'b1;
      12: begin m[6] = 1'b1; m[4] = 1'b1; m[1] = 1'b1; end
      13: begin m[4] = 1'b1; m[3] = 1'b1; m[1] = 1'b1; end
      14: begin m[10] = 1'b1; m[6] = 1'b1; m[1] = 1'b1; end
      15: m[1] = 1'b1;
      16: begin m[12] = 1'b1; m[3] = 1'b1; m[1] = 1'b1; end
      default: m = '0;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/bilbo_input_mux.sv
module bilbo_input_mux #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] d_i,
  input  logic             pgen_i,
  output logic [WIDTH-1:0] din_o
);

  localparam logic [WIDTH-1:0] FILL = {WIDTH{1'b1}};

  always_comb begin
    if (pgen_i) begin
      din_o = FILL;
    end else begin
      din_o = d_i;
    end
  end

endmodule

// File: rtl/bilbo_feedback.sv
module bilbo_feedback #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] q_i,
  output logic             fb_o
);
  import bilbo_pkg::*;

  localparam logic [MAX_WIDTH-1:0] MID = poly_mid_terms(WIDTH);

  // stage W-1-k contributes for each middle exponent k, plus the last stage
  logic [WIDTH-1:0] tap_sel;

  for (genvar k = 0; k < WIDTH; k++) begin : g_tap
    if (k == 0) begin : g_const
      assign tap_sel[WIDTH-1] = q_i[WIDTH-1];
    end else if (MID[k]) begin : g_used
      assign tap_sel[WIDTH-1-k] = q_i[WIDTH-1-k];
    end else begin : g_unused
      assign tap_sel[WIDTH-1-k] = 1'b0;
    end
  end

  assign fb_o = ^tap_sel;

endmodule

// File: rtl/bilbo_next_state.sv
module bilbo_next_state #(
  parameter int unsigned WIDTH = 8
) (
  input  bilbo_pkg::bilbo_mode_e mode_i,
  input  logic [WIDTH-1:0]       q_i,
  input  logic [WIDTH-1:0]       d_i,
  input  logic [WIDTH-1:0]       din_i,
  input  logic                   fb_i,
  input  logic                   scan_i,
  output logic [WIDTH-1:0]       nxt_o
);
  import bilbo_pkg::*;

  // value entering each stage from the left neighbour
  logic [WIDTH-1:0] from_left;

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_comb begin
        from_left[i] = (mode_i == MODE_LFSR) ? fb_i : scan_i;
      end
    end else begin : g_body
      always_comb begin
        from_left[i] = q_i[i-1];
      end
    end

    always_comb begin
      unique case (mode_i)
        MODE_LOAD:  nxt_o[i] = d_i[i];
        MODE_SCAN:  nxt_o[i] = from_left[i];
        MODE_LFSR:  nxt_o[i] = from_left[i] ^ din_i[i];
        MODE_CLEAR: nxt_o[i] = 1'b0;
        default:    nxt_o[i] = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/bilbo_reg.sv
module bilbo_reg #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       mode_i,
  input  logic             pgen_i,
  input  logic [WIDTH-1:0] d_i,
  input  logic             scan_i,
  output logic [WIDTH-1:0] q_o,
  output logic             scan_o
);
  import bilbo_pkg::*;

  if (WIDTH < MIN_WIDTH || WIDTH > MAX_WIDTH) begin : g_bad_width
    $error("bilbo_reg: WIDTH outside the polynomial table");
  end

  // reset: asserts at once, releases after two edges
  logic [1:0] rst_sync_q;
  logic       rst_n_int;
  logic       live_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n_int = rst_sync_q[1];

  // marks cycles where the previous edge was a normal update
  always_ff @(posedge clk_i or negedge rst_n_int) begin
    if (!rst_n_int) begin
      live_q <= 1'b0;
    end else begin
      live_q <= 1'b1;
    end
  end

  bilbo_mode_e      mode;
  logic [WIDTH-1:0] state_q;
  logic [WIDTH-1:0] state_d;
  logic [WIDTH-1:0] din;
  logic             fb;

  assign mode = bilbo_mode_e'(mode_i);

  bilbo_input_mux #(.WIDTH(WIDTH)) u_mux (
    .d_i    (d_i),
    .pgen_i (pgen_i),
    .din_o  (din)
  );

  bilbo_feedback #(.WIDTH(WIDTH)) u_fb (
    .q_i  (state_q),
    .fb_o (fb)
  );

  bilbo_next_state #(.WIDTH(WIDTH)) u_nxt (
    .mode_i (mode),
    .q_i    (state_q),
    .d_i    (d_i),
    .din_i  (din),
    .fb_i   (fb),
    .scan_i (scan_i),
    .nxt_o  (state_d)
  );

  always_ff @(posedge clk_i or negedge rst_n_int) begin
    if (!rst_n_int) begin
      state_q <= '0;
    end else begin
      state_q <= state_d;
    end
  end

  assign q_o    = state_q;
  assign scan_o = state_q[WIDTH-1];

  // R1: parallel capture
  p_load_r1: assert property (@(posedge clk_i) disable iff (!live_q)
    mode_i == 2'b11 |=> q_o == $past(d_i));

  // R2: serial shift, head takes the serial input
  p_scan_shift_r2: assert property (@(posedge clk_i) disable iff (!live_q)
    mode_i == 2'b00 |=> (q_o[0] == $past(scan_i)) && (q_o[WIDTH-1:1] == $past(q_o[WIDTH-2:0])));

  // R7: serial output shows the bit shifted out of stage W-2
  p_scan_out_r7: assert property (@(posedge clk_i) disable iff (!live_q)
    mode_i == 2'b00 |=> scan_o == $past(q_o[WIDTH-2]));

  // R3: head of the chain in feedback mode follows the feedback network
  p_lfsr_head_r3: assert property (@(posedge clk_i) disable iff (!live_q)
    (mode_i == 2'b01 && !pgen_i) |=> q_o[0] == $past(fb ^ d_i[0]));

  // R4: synchronous clear
  p_clear_r4: assert property (@(posedge clk_i) disable iff (!live_q)
    mode_i == 2'b10 |=> q_o == '0);

  // R5: pattern generation inverts the shifted bits
  p_pgen_invert_r5: assert property (@(posedge clk_i) disable iff (!live_q)
    (mode_i == 2'b01 && pgen_i) |=> q_o[WIDTH-1:1] == ~$past(q_o[WIDTH-2:0]));

endmodule

// File: tb/sim_bilbo_reg.sv
module sim_bilbo_reg;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_ni;
  logic [1:0]   mode;
  logic         pgen;
  logic [W-1:0] d;
  logic         sin;
  logic [W-1:0] q;
  logic         sout;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] exp_q;

  always #2 clk = ~clk;

  bilbo_reg #(.WIDTH(W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode), .pgen_i(pgen),
    .d_i(d), .scan_i(sin), .q_o(q), .scan_o(sout)
  );

  // reference model from the requirements (width 8 polynomial x^8+x^6+x^5+x^4+1)
  function automatic logic [W-1:0] model(input logic [W-1:0] s, input logic [1:0] m,
                                         input logic [W-1:0] dd, input logic si, input logic pg);
    logic [W-1:0] r;
    logic [W-1:0] dv;
    logic         f;
    dv = pg ? {W{1'b1}} : dd;
    f  = s[7] ^ s[1] ^ s[2] ^ s[3];
    case (m)
      2'b11:   r = dd;
      2'b00:   r = {s[W-2:0], si};
      2'b01:   r = {s[W-2:0], f} ^ dv;
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic step(input string tag, input logic [1:0] m, input logic [W-1:0] dd,
                      input logic si, input logic pg);
    @(negedge clk);
    mode = m; d = dd; sin = si; pgen = pg;
    exp_q = model(exp_q, m, dd, si, pg);
    @(posedge clk);
    #1;
    chk(tag, q, exp_q);
    chk("R7", {{(W-1){1'b0}}, sout}, {{(W-1){1'b0}}, exp_q[W-1]});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    mode = 2'b10;
    #1;
    chk("R8", q, '0);
    @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    exp_q = '0;
    chk("R8", q, '0);
  endtask

  initial begin
    #(4 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int dummy;
    int n;
    string tg;
    dummy = $urandom(32'h5eed_b11b);
    rst_ni = 1'b0; mode = 2'b10; pgen = 1'b0; d = '0; sin = 1'b0;
    exp_q = '0;
    #5;
    chk("R8", q, '0);
    do_reset();

    // directed corners
    step("R1", 2'b11, 8'h5a, 1'b0, 1'b0);
    step("R6", 2'b11, 8'ha5, 1'b1, 1'b1);
    step("R4", 2'b10, 8'hff, 1'b1, 1'b0);
    step("R2", 2'b00, 8'hff, 1'b1, 1'b1);
    step("R2", 2'b00, 8'h00, 1'b0, 1'b0);
    step("R5", 2'b01, 8'h3c, 1'b0, 1'b1);
    step("R5", 2'b01, 8'h00, 1'b0, 1'b1);
    step("R3", 2'b01, 8'h81, 1'b0, 1'b0);

    // random mix of modes
    for (int i = 0; i < 400; i++) begin
      logic [1:0] m;
      m = 2'($urandom_range(0, 3));
      case (m)
        2'b11:   tg = "R1";
        2'b00:   tg = "R2";
        2'b10:   tg = "R4";
        default: tg = "R3";
      endcase
      step(tg, m, W'($urandom), 1'($urandom), 1'($urandom));
    end

    // reset in the middle of a run
    step("R1", 2'b11, 8'hc3, 1'b0, 1'b0);
    do_reset();

    // full sequence length from seed 1
    step("R1", 2'b11, 8'h01, 1'b0, 1'b0);
    n = 0;
    for (int i = 0; i < 300; i++) begin
      step("R3", 2'b01, 8'h00, 1'b0, 1'b0);
      n++;
      if (q == 8'h01) break;
    end
    chk("R9", W'(n), W'(255));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule